// File: doc/BRIEF.md
# Key-Protected SDRAM Controller Register Bank

This block is the software-visible configuration space of an SDRAM controller: 64 words of 32 bits, reached through a plain word-wide bus. The bus has a byte address, a write strobe, write data and registered read data, and decodes a 4 KB window. A protection word at the bottom of the window gates every other write. Only one magic key value opens the bank. Any other value written there closes it again.

The configuration word has fields that software may not change. On every accepted write, those fields are cleared from the incoming data, and a build-time constant is then OR-ed in. That constant carries the hardware version, status flags and the memory-size code. A generation parameter chooses between two controller families, which differ in their protected fields and in their size code table. The newer family also has a PHY status word whose busy flag can never be stored as set.

The block models register behaviour only. It has no DRAM timing, PHY, ECC, scrambling or cache logic.

Top module: `memctl_keyed_regs`

## Requirements
- R1: A write to byte offset 0x00 is always accepted. Data of exactly 0xFC600309 stores 1 (unlocked), and any other data stores 0 (locked). The word then reads back as 1 or 0.
- R2: While offset 0x00 holds 0, writes to every other offset leave the stored contents unchanged.
- R3: On an unlocked write to offset 0x04, the bits in the read-only mask are cleared from the data and the fixed value is OR-ed in. With GEN=0 the mask is bits 31:11, bit 6 and bits 3:2. With GEN=1 the mask is bits 31:28, bits 19:14, bit 6 and bits 3:2.
- R4: The fixed value for GEN=0 is bit 6 set plus the size code in bits 1:0. The fixed value for GEN=1 is 1 in bits 31:28, bit 19 set, bits 3:2 = 3, plus the size code in bits 1:0.
- R5: Size codes are as follows. For GEN=0, MEM_MB of 64, 128, 256 and 512 give 0, 1, 2 and 3. For GEN=1, 128, 256, 512 and 1024 give 0, 1, 2 and 3. Any other MEM_MB gives code 2, which is 256 MB for GEN=0 and 512 MB for GEN=1.
- R6: With GEN=1, an unlocked write to offset 0x60 stores bit 0 as 0 and the other bits as written. With GEN=0 that offset stores the data unchanged.
- R7: After reset every word reads 0, except offset 0x04, which reads the fixed value. The bank starts locked.
- R8: The word index is the byte address shifted right by 2. An index of 64 or more reads 0, and a write to it changes no stored word.
- R9: Read data is registered. The word at the address presented in one cycle appears on rd_data after the next rising edge. Offsets without special rules store the written data as-is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W (12) | Byte address within the window |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |

## Verification
The bench builds two instances that share one bus. The first uses GEN=1 with MEM_MB=1024, which gives the top size code, the version and cache-done fields, and the busy-bit rule at 0x60. The second uses GEN=0 with an unsupported MEM_MB of 300, which exercises the fallback code and the wide reserved mask of the older family. Together the two cover both mask tables, both reset values and both behaviours of the status offset within a single run.

// File: rtl/memctl_keyed_regs.sv
module memctl_keyed_regs #(
  parameter int GEN    = 1,
  parameter int MEM_MB = 512,
  parameter int ADDR_W = 12,
  parameter int WORDS  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data
);
  localparam int          IDX_W    = ADDR_W - 2;
  localparam int          SEL_W    = $clog2(WORDS);
  localparam logic [31:0] KEY      = 32'hFC60_0309;
  localparam int          CONF_IDX = 1;
  localparam int          STAT_IDX = 24;

  function automatic logic [1:0] size_code(input int gen, input int mb);
    if (gen == 0) begin
      case (mb)
        64:      return 2'd0;
        128:     return 2'd1;
        512:     return 2'd3;
        default: return 2'd2;
      endcase
    end else begin
      case (mb)
        128:     return 2'd0;
        256:     return 2'd1;
        1024:    return 2'd3;
        default: return 2'd2;
      endcase
    end
  endfunction

  localparam logic [1:0]  CODE    = size_code(GEN, MEM_MB);
  localparam logic [31:0] RO_MASK = (GEN == 0) ? 32'hFFFF_F84C : 32'hF00F_C04C;
  localparam logic [31:0] FIXED   = (GEN == 0) ? {24'h0, 8'h40} | {30'h0, CODE}
                                               : 32'h1008_000C | {30'h0, CODE};

  logic [31:0]      mem [WORDS];
  logic [IDX_W-1:0] idx;
  logic [SEL_W-1:0] sel;
  logic             in_range;
  logic             unlocked;
  logic [31:0]      wval;

  assign idx      = addr[ADDR_W-1:2];
  assign sel      = idx[SEL_W-1:0];
  assign in_range = (idx < IDX_W'(WORDS));
  assign unlocked = mem[0][0];

  always_comb begin
    wval = wr_data;
    if (sel == SEL_W'(CONF_IDX))
      wval = (wr_data & ~RO_MASK) | FIXED;
    else if (GEN == 1 && sel == SEL_W'(STAT_IDX))
      wval = wr_data & ~32'h1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
      mem[CONF_IDX] <= FIXED;
    end else if (wr_en && in_range) begin
      if (sel == '0)
        mem[0] <= {31'h0, wr_data == KEY};
      else if (unlocked)
        mem[sel] <= wval;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= in_range ? mem[sel] : '0;
  end
endmodule

module memctl_keyed_regs_chk #(
  parameter int          GEN     = 1,
  parameter int          ADDR_W  = 12,
  parameter int          WORDS   = 64,
  parameter logic [31:0] RO_MASK = '0,
  parameter logic [31:0] FIXED   = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [31:0]       wr_data,
  input logic [31:0]       rd_data,
  input logic [31:0]       prot_w,
  input logic [31:0]       conf_w,
  input logic [31:0]       stat_w
);
  logic oob;
  assign oob = (addr[ADDR_W-1:2] >= (ADDR_W-2)'(WORDS));

  a_r1_key_decode: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[ADDR_W-1:2] == '0) |=> (prot_w == {31'h0, $past(wr_data) == 32'hFC60_0309}));

  a_r2_locked_conf: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && prot_w == 0 && addr[ADDR_W-1:2] != '0) |=> $stable(conf_w));

  a_r3_ro_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (conf_w & RO_MASK) == (FIXED & RO_MASK));

  a_r6_never_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (GEN == 1) |-> (stat_w[0] == 1'b0));

  a_r8_oob_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    oob |=> (rd_data == '0));
endmodule

bind memctl_keyed_regs memctl_keyed_regs_chk #(
  .GEN(GEN), .ADDR_W(ADDR_W), .WORDS(WORDS), .RO_MASK(RO_MASK), .FIXED(FIXED)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .prot_w(mem[0]), .conf_w(mem[1]), .stat_w(mem[24])
);

// File: tb/sim_memctl_keyed_regs.sv
module sim_memctl_keyed_regs;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [11:0] addr = '0;
  logic        wr_en = 0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_b, rd_a;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  localparam logic [31:0] KEY   = 32'hFC60_0309;
  localparam logic [31:0] RO_B  = 32'hF000_0000 | 32'h0008_0000 | 32'h0007_C000 | 32'h40 | 32'hC;
  localparam logic [31:0] FIX_B = 32'h1000_0000 | 32'h0008_0000 | 32'hC | 32'h3;
  localparam logic [31:0] RO_A  = 32'hFFFF_F800 | 32'h40 | 32'hC;
  localparam logic [31:0] FIX_A = 32'h40 | 32'h2;

  always #4 clk = ~clk;

  memctl_keyed_regs #(.GEN(1), .MEM_MB(1024)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_b));
  memctl_keyed_regs #(.GEN(0), .MEM_MB(300)) u1 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_a));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd2(input logic [11:0] a, input string req,
                     input logic [31:0] exp_b, input logic [31:0] exp_a);
    @(negedge clk); addr = a; wr_en = 0;
    @(negedge clk);
    check({req, " genB"}, rd_b, exp_b);
    check({req, " genA"}, rd_a, exp_a);
  endtask

  task automatic t_reset();
    rd2(12'h000, "R7 prot", 0, 0);
    rd2(12'h004, "R7 R4 R5 conf", FIX_B, FIX_A);
    rd2(12'h060, "R7 status", 0, 0);
    rd2(12'h0FC, "R7 last", 0, 0);
  endtask

  task automatic t_locked();
    wr(12'h004, 32'hFFFF_FFFF);
    wr(12'h008, 32'hA5A5_A5A5);
    rd2(12'h004, "R2 conf locked", FIX_B, FIX_A);
    rd2(12'h008, "R2 word locked", 0, 0);
  endtask

  task automatic t_unlock_and_conf();
    wr(12'h000, KEY);
    rd2(12'h000, "R1 key", 1, 1);
    wr(12'h004, 32'hFFFF_FFFF);
    rd2(12'h004, "R3 conf ones", (32'hFFFF_FFFF & ~RO_B) | FIX_B, (32'hFFFF_FFFF & ~RO_A) | FIX_A);
    wr(12'h004, 32'h0);
    rd2(12'h004, "R3 conf zero", FIX_B, FIX_A);
    wr(12'h004, 32'h0000_0130);
    rd2(12'h004, "R3 conf mix", (32'h130 & ~RO_B) | FIX_B, (32'h130 & ~RO_A) | FIX_A);
  endtask

  task automatic t_status();
    wr(12'h060, 32'hFFFF_FFFF);
    rd2(12'h060, "R6 status ones", 32'hFFFF_FFFE, 32'hFFFF_FFFF);
    wr(12'h060, 32'h0000_0001);
    rd2(12'h060, "R6 status busy", 0, 1);
  endtask

  task automatic t_plain();
    wr(12'h008, 32'h1234_5678);
    wr(12'h0FC, 32'hCAFE_F00D);
    rd2(12'h008, "R9 plain", 32'h1234_5678, 32'h1234_5678);
    rd2(12'h0FC, "R9 last word", 32'hCAFE_F00D, 32'hCAFE_F00D);
    rd2(12'h00B, "R9 byte bits dropped", 32'h1234_5678, 32'h1234_5678);
  endtask

  task automatic t_oob();
    wr(12'h100, 32'h0000_0000);
    wr(12'h108, 32'hDEAD_BEEF);
    rd2(12'h000, "R8 no alias prot", 1, 1);
    rd2(12'h008, "R8 no alias word", 32'h1234_5678, 32'h1234_5678);
    rd2(12'h108, "R8 oob read", 0, 0);
    rd2(12'hFFC, "R8 top read", 0, 0);
  endtask

  task automatic t_relock();
    wr(12'h000, KEY ^ 32'h1);
    rd2(12'h000, "R1 bad key", 0, 0);
    wr(12'h008, 32'h0BAD_0BAD);
    rd2(12'h008, "R2 relocked", 32'h1234_5678, 32'h1234_5678);
    wr(12'h000, KEY);
    wr(12'h000, 32'h0);
    rd2(12'h000, "R1 lock by zero", 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_locked();
    t_unlock_and_conf();
    t_status();
    t_plain();
    t_oob();
    t_relock();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule